// File: doc/BRIEF.md
# Configurable-Policy DMA Channel Arbiter

This block decides which DMA channel the transfer engine serves next. Each cycle it looks at the per-channel request lines and a global enable bit. It also reads a two-bit policy field, which the surrounding controller takes from bits 9:8 of its global control word. From these it presents one granted channel as a one-hot vector, as a binary index and with a valid flag. Three of the policy codes select fixed ranking permutations over eight channel slots. The fourth code selects a rotating round-robin scheme.

Eight slots are arbitrated. A parameterised presence mask zeroes the requests of slots that have no channel behind them; by default slots 0 to 5 are present. Once a grant has been shown and not accepted, it stays on the same channel until the engine accepts it or the channel withdraws its request. A change of policy therefore only matters at the next fresh decision. The grant outputs are combinational from the inputs and two small state registers: a hold register and a round-robin pointer.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While the synchronous reset is high, no grant is issued. After reset the round-robin pointer is at channel 0, so with policy 3 and all present channels requesting, channel 0 is granted first, and no grant is held over from before reset.
- R2: While the enable input is low, grantValid is 0 and the grant vector is all zero, whatever the requests.
- R3: A request on a slot whose PRESENT_MASK bit is 0 is ignored. If only such slots request, grantValid stays 0, and such a slot is never granted.
- R4: grantValid is 1 exactly when reset is low, enable is high and at least one present channel requests.
- R5: Policy code 0 ranks channels 0,1,2,3,4,5,6,7 from highest to lowest.
- R6: Policy code 1 ranks channels 0,2,3,1,4,6,7,5 from highest to lowest.
- R7: Policy code 2 ranks channels 2,0,1,3,6,4,5,7 from highest to lowest.
- R8: Policy code 3 is round robin. The search starts at the pointer channel and goes upward, wrapping from 7 to 0, and grants the first present requester.
- R9: The pointer moves to (granted index + 1) mod 8 only on a cycle where grantValid and engAccept are both 1, under any policy. Otherwise it keeps its value.
- R10: A grant that was valid and not accepted in one cycle is presented again in the next cycle on the same channel, even if the policy or other requests change, provided enable is still high and that channel still requests.
- R11: grantOneHot has at most one bit set. When grantValid is 1, that bit is at position grantIdx. grantIdx is 0 when grantValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chanReq | input | 8 | Request line per channel slot |
| ctrlEnable | input | 1 | Global enable; grants only when high |
| ctrlPolicy | input | 2 | Ranking policy code (0..3) |
| engAccept | input | 1 | Transfer engine takes the current grant |
| grantOneHot | output | 8 | One-hot grant vector |
| grantIdx | output | 3 | Binary index of the granted channel |
| grantValid | output | 1 | A grant is being offered |

## Verification
The grant outputs respond in the same cycle as the inputs that produce them. The hold register and the round-robin pointer change only at the clock edge, so their effect on the grant appears one cycle after the accept or non-accept that caused it. The bench drives inputs just after the falling edge and compares the outputs 1 ns later, still before the rising edge. At that rising edge it updates its own behavioural hold and pointer state, so every expected value includes exactly the state changes from the previous edges.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int IDX_W = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic holdLoad;
    logic ptrAdvance;
  } arbStrobes_t;

  // channel occupying a given rank slot under a fixed policy (0..2)
  function automatic logic [IDX_W-1:0] rankChan(input logic [1:0] pol,
                                                input logic [IDX_W-1:0] slot);
    logic [1:0] low;
    low = slot[1:0];
    case (pol)
      2'd1: case (slot[1:0])
              2'd0: low = 2'd0;
              2'd1: low = 2'd2;
              2'd2: low = 2'd3;
              default: low = 2'd1;
            endcase
      2'd2: case (slot[1:0])
              2'd0: low = 2'd2;
              2'd1: low = 2'd0;
              2'd2: low = 2'd1;
              default: low = 2'd3;
            endcase
      default: low = slot[1:0];
    endcase
    return {slot[2], low};
  endfunction
endpackage

// File: rtl/dma_arb_control.sv
module dma_arb_control
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrlEnable,
  input  logic        engAccept,
  input  logic        anyReq,
  output logic        grantValid,
  output arbStrobes_t strobes
);
  always_comb begin
    grantValid = !rst && ctrlEnable && anyReq;
    strobes.holdLoad = grantValid && !engAccept;
    strobes.ptrAdvance = grantValid && engAccept;
  end

  // R2
  disabled_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrlEnable |-> !grantValid);

  // R10
  hold_excludes_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobes.holdLoad && strobes.ptrAdvance));
endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] PRESENT_MASK = 8'h3F
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] chanReq,
  input  logic [1:0]           ctrlPolicy,
  input  arbStrobes_t          strobes,
  input  logic                 grantValid,
  output logic                 anyReq,
  output logic [IDX_W-1:0]     grantIdx,
  output logic [NUM_SLOTS-1:0] grantOneHot
);
  localparam logic [1:0] POL_ROUND = 2'd3;

  logic [NUM_SLOTS-1:0] reqMasked;
  logic [IDX_W-1:0]     fixedPick, rrPick, freshPick, chosen;
  logic [IDX_W-1:0]     holdIdx, rrPtr;
  logic                 holdValid, holdAlive;

  assign reqMasked = chanReq & PRESENT_MASK;
  assign anyReq    = |reqMasked;

  // fixed ranking: walk from lowest rank to highest so the best wins last
  always_comb begin
    fixedPick = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (reqMasked[rankChan(ctrlPolicy, IDX_W'(s))])
        fixedPick = rankChan(ctrlPolicy, IDX_W'(s));
    end
  end

  // rotating ranking starting at the pointer
  always_comb begin
    rrPick = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (reqMasked[rrPtr + IDX_W'(k)])
        rrPick = rrPtr + IDX_W'(k);
    end
  end

  assign freshPick = (ctrlPolicy == POL_ROUND) ? rrPick : fixedPick;
  assign holdAlive = holdValid && reqMasked[holdIdx];
  assign chosen    = holdAlive ? holdIdx : freshPick;
  assign grantIdx  = grantValid ? chosen : '0;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gOneHot
    assign grantOneHot[g] = grantValid && (chosen == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdValid <= 1'b0;
      holdIdx   <= '0;
      rrPtr     <= '0;
    end else begin
      holdValid <= strobes.holdLoad;
      if (strobes.holdLoad) holdIdx <= chosen;
      if (strobes.ptrAdvance) rrPtr <= chosen + IDX_W'(1);
    end
  end

  // R9
  ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.ptrAdvance |=> rrPtr == $past(grantIdx) + IDX_W'(1));

  // R9
  ptr_still_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.ptrAdvance |=> $stable(rrPtr));

  // R3
  absent_never_granted_chk: assert property (@(posedge clk) disable iff (rst)
    (grantOneHot & ~PRESENT_MASK) == '0);

  // R10
  grant_held_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.holdLoad |=> (!(grantValid && chanReq[$past(grantIdx)]) ||
                          grantIdx == $past(grantIdx)));
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter logic [7:0] PRESENT_MASK = 8'h3F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] chanReq,
  input  logic       ctrlEnable,
  input  logic [1:0] ctrlPolicy,
  input  logic       engAccept,
  output logic [7:0] grantOneHot,
  output logic [2:0] grantIdx,
  output logic       grantValid
);
  arbStrobes_t strobes;
  logic        anyReq;

  dma_arb_control u_ctrl (
    .clk(clk), .rst(rst), .ctrlEnable(ctrlEnable), .engAccept(engAccept),
    .anyReq(anyReq), .grantValid(grantValid), .strobes(strobes)
  );

  dma_arb_datapath #(.PRESENT_MASK(PRESENT_MASK)) u_dp (
    .clk(clk), .rst(rst), .chanReq(chanReq), .ctrlPolicy(ctrlPolicy),
    .strobes(strobes), .grantValid(grantValid), .anyReq(anyReq),
    .grantIdx(grantIdx), .grantOneHot(grantOneHot)
  );

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantOneHot) && (grantValid == (grantOneHot != '0)));

  // R4
  valid_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    grantValid |-> ctrlEnable && ((chanReq & PRESENT_MASK) != '0));
endmodule

// File: tb/dma_chan_arbiter_tb.sv
`timescale 1ns/1ps
module dma_chan_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] chanReq = '0;
  logic       ctrlEnable = 1'b0;
  logic [1:0] ctrlPolicy = '0;
  logic       engAccept = 1'b0;
  logic [7:0] grantOneHot;
  logic [2:0] grantIdx;
  logic       grantValid;

  localparam logic [7:0] MASK = 8'h3F;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural model state
  int mHoldV = 0;
  int mHoldI = 0;
  int mPtr = 0;
  int order[3][8] = '{'{0,1,2,3,4,5,6,7}, '{0,2,3,1,4,6,7,5}, '{2,0,1,3,6,4,5,7}};

  always #2.5 clk = ~clk;

  dma_chan_arbiter u_dut (
    .clk(clk), .rst(rst), .chanReq(chanReq), .ctrlEnable(ctrlEnable),
    .ctrlPolicy(ctrlPolicy), .engAccept(engAccept), .grantOneHot(grantOneHot),
    .grantIdx(grantIdx), .grantValid(grantValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // apply one cycle of stimulus, compare, then advance the model at the edge
  task automatic step(input bit r, input bit en, input int pol, input logic [7:0] req,
                      input bit acc);
    logic [7:0] reqM;
    int expV, expI, fresh;
    bit hold;
    string tag;
    @(negedge clk);
    rst = r; ctrlEnable = en; ctrlPolicy = 2'(pol); chanReq = req; engAccept = acc;
    #1;
    reqM = req & MASK;
    expV = (!r && en && reqM != 0) ? 1 : 0;
    hold = (mHoldV != 0) && reqM[mHoldI];
    fresh = 0;
    if (pol < 3) begin
      for (int s = 7; s >= 0; s--) if (reqM[order[pol][s]]) fresh = order[pol][s];
    end else begin
      for (int k = 7; k >= 0; k--) if (reqM[(mPtr + k) % 8]) fresh = (mPtr + k) % 8;
    end
    expI = hold ? mHoldI : fresh;
    if (r) tag = "R1";
    else if (!en) tag = "R2";
    else if (req != 0 && reqM == 0) tag = "R3";
    else if (hold) tag = "R10";
    else if (pol == 0) tag = "R5";
    else if (pol == 1) tag = "R6";
    else if (pol == 2) tag = "R7";
    else tag = "R8,R9";
    check(grantValid == expV[0], "R4 valid", int'(grantValid), expV);
    check(int'(grantIdx) == (expV != 0 ? expI : 0), tag, int'(grantIdx),
          expV != 0 ? expI : 0);
    // R11: one-hot consistency computed independently
    check(grantOneHot == (expV != 0 ? (8'h01 << expI) : 8'h00), "R11 onehot",
          int'(grantOneHot), expV != 0 ? (1 << expI) : 0);
    @(posedge clk);
    if (r) begin
      mHoldV = 0; mPtr = 0;
    end else begin
      mHoldV = (expV != 0 && !acc) ? 1 : 0;
      mHoldI = expI;
      if (expV != 0 && acc) mPtr = (expI + 1) % 8;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds grants off
    step(1, 1, 3, 8'hFF, 1);
    step(1, 1, 0, 8'h3F, 0);
    // R1: pointer starts at channel 0
    step(0, 1, 3, 8'h3F, 1);
    step(0, 1, 3, 8'h3F, 1);
    // R2: disabled
    step(0, 0, 0, 8'h3F, 0);
    // R3: absent slots only
    step(0, 1, 0, 8'hC0, 1);
    step(0, 1, 3, 8'hC0, 1);
    // R5..R7: each policy with all present requesting and accepting
    for (int p = 0; p < 3; p++) begin
      step(0, 1, p, 8'h3F, 1);
      step(0, 1, p, 8'h3E, 1);
      step(0, 1, p, 8'h3A, 1);
      step(0, 1, p, 8'h30, 1);
      step(0, 1, p, 8'h60, 1);
    end
    // R10: hold then policy change, then drop request
    step(0, 1, 0, 8'h0C, 0);
    step(0, 1, 2, 8'h0C, 0);
    step(0, 1, 2, 8'h08, 0);
    step(0, 1, 2, 8'h0C, 1);
    // R9: no accept keeps pointer; wrap from 5 past absent 6,7
    step(0, 1, 3, 8'h20, 1);
    step(0, 1, 3, 8'h3F, 0);
    step(0, 1, 3, 8'h00, 0);
    step(0, 1, 3, 8'h3F, 1);
    // reset mid-run clears pointer and hold (R1)
    step(0, 1, 3, 8'h10, 0);
    step(1, 1, 3, 8'h10, 0);
    step(0, 1, 3, 8'h3F, 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 500) == 0, ($urandom % 10) != 0,
           (i / 150) % 4 == 3 ? int'($urandom % 4) : (i / 150) % 4,
           8'($urandom), ($urandom % 2) == 1);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule